// File: doc/BRIEF.md
# Serial Flash Page Geometry Probe

This block works out the page layout of a page-organised serial flash that sits behind a dedicated SPI port. After reset it waits for a single start pulse. It then clocks out a JEDEC identification command and reads back a manufacturer byte and a two-byte device code. If the manufacturer byte is the expected one, the device code is looked up in an internal table. Devices that can run with either page size need one more step: the block reads the status byte, and its bit 0 chooses between binary (power-of-two) pages and extended pages. If the manufacturer byte does not match, the block treats the part as an older device. It reads the status byte and decodes a density code from bits 5:2.

When the probe ends, the block presents the number of pages, the bytes per page and the address shift that places a page number above the in-page byte offset. It raises either a valid flag or an unsupported flag, never both. The result then stays frozen until reset, so a memory controller downstream can sample it at any time after completion.

Top module: `flash_geom_probe`

## Requirements
- R1: During and after reset, and until a start pulse: `flash_cs_n` is 1, `flash_sclk` is 0, `geo_valid` and `geo_unsupported` are 0, and the geometry outputs are 0.
- R2: A start pulse in the idle state begins one chip-select transaction. In SPI mode 0, MSB first, the block sends opcode 0x9F and then reads three bytes: manufacturer, device code high byte, device code low byte. While `flash_cs_n` is 1, `flash_sclk` is 0.
- R3: When the manufacturer byte is 0x1F and the device code is 0x2200, 0x2300, 0x2400, 0x2500, 0x2600, 0x2701 or 0x2800, a second transaction sends opcode 0xD7 and reads one status byte. If status bit 0 is 1, the result is binary pages: size 2^shift, with shift 8 for codes 0x22xx–0x25xx, shift 9 for 0x2600 and 0x2701, and shift 10 for 0x2800.
- R4: In the R3 case with status bit 0 equal to 0, the result is extended pages: 264 bytes with shift 9 for 0x22xx–0x25xx, 528 with shift 10 for 0x2600 and 0x2701, and 1056 with shift 11 for 0x2800.
- R5: The page counts for the identified codes are 0x2200→512, 0x2300→1024, 0x2400→2048, 0x2500 and 0x2600→4096, and 0x2700, 0x2701 and 0x2800→8192.
- R6: Device code 0x2700 (with manufacturer 0x1F) gives 8192 pages of 528 bytes with shift 10. No status transaction is made.
- R7: A manufacturer byte of 0x1F with a device code not listed in R3 or R6 sets `geo_unsupported`. No status transaction is made.
- R8: Any other manufacturer byte leads to a status transaction (opcode 0xD7). The code status&0x3C then decodes as follows, always to extended pages: 0x0C→512×264 (shift 9), 0x14→1024×264, 0x1C→2048×264, 0x24→4096×264, 0x2C→4096×528 (shift 10), 0x34→8192×528, and 0x38 or 0x3C→8192×1056 (shift 11).
- R9: On the older-device path, a status byte of 0x00 or 0xFF means no device is present and sets `geo_unsupported`.
- R10: On the older-device path, any other code of status&0x3C sets `geo_unsupported`.
- R11: Once `geo_valid` or `geo_unsupported` is 1, every output stays constant and `flash_cs_n` stays 1 until reset. Further start pulses cause no transaction.
- R12: `geo_valid` and `geo_unsupported` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches the probe |
| flash_sclk | output | 1 | SPI serial clock (mode 0) |
| flash_cs_n | output | 1 | SPI chip select, active low |
| flash_mosi | output | 1 | SPI data to the flash |
| flash_miso | input | 1 | SPI data from the flash |
| page_count | output | 14 | Number of pages |
| page_size | output | 11 | Bytes per page |
| page_shift | output | 4 | Bit position of the page number in a flash address |
| geo_valid | output | 1 | Geometry found and outputs valid |
| geo_unsupported | output | 1 | Probe finished without a usable geometry |

## Verification
The bench builds the block with CLK_DIV=2, so a probe of two transactions finishes in a few hundred cycles. This makes it practical to reset and re-probe against a behavioural flash model once per scenario. The default command and manufacturer codes are kept, so the model answers with the real opcode values. That brings into reach both page-size choices on the identified path, the fixed-size code, an unknown code from the right manufacturer, several density codes on the older path, the absent-device status values and an undefined density code.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;
  localparam int PCNT_W  = 14;
  localparam int PSIZE_W = 11;
  localparam int SHIFT_W = 4;

  typedef struct packed {
    logic [PCNT_W-1:0]  pcnt;
    logic [PSIZE_W-1:0] psize;
    logic [SHIFT_W-1:0] shift;
  } geo_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ID_OP, S_ID_MFR, S_ID_HI, S_ID_LO, S_EVAL,
    S_GAP, S_ST_OP, S_ST_RD, S_FINAL, S_DONE
  } probe_state_t;
endpackage

// File: rtl/fp_spi_shifter.sv
module fp_spi_shifter #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx_byte,
  output logic [7:0] rx_byte,
  output logic       done,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic             busy;
  logic [DIV_W-1:0] div_cnt;
  logic [3:0]       edge_cnt;
  logic [7:0]       tx_sh;
  logic [7:0]       rx_sh;

  assign mosi    = tx_sh[7];
  assign rx_byte = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      sclk     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy     <= 1'b1;
          tx_sh    <= tx_byte;
          div_cnt  <= '0;
          edge_cnt <= '0;
          sclk     <= 1'b0;
        end
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        sclk    <= ~sclk;
        if (!sclk) rx_sh <= {rx_sh[6:0], miso};
        else       tx_sh <= {tx_sh[6:0], 1'b0};
        edge_cnt <= edge_cnt + 4'd1;
        if (edge_cnt == 4'd15) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/fp_geo_decode.sv
module fp_geo_decode
  import flash_probe_pkg::*;
(
  input  logic        legacy,
  input  logic [15:0] dev_id,
  input  logic [7:0]  status,
  output logic        hit,
  output logic        dual,
  output geo_t        geo
);
  logic [PCNT_W-1:0]  cnt;
  logic [SHIFT_W-1:0] ext_shift;
  logic [PSIZE_W-1:0] pow2_part, tail_part;

  always_comb begin
    hit       = 1'b0;
    dual      = 1'b0;
    cnt       = '0;
    ext_shift = '0;
    if (legacy) begin
      if (status != 8'h00 && status != 8'hFF) begin
        case (status & 8'h3C)
          8'h0C: begin hit = 1'b1; cnt = PCNT_W'(512);  ext_shift = 4'd9;  end
          8'h14: begin hit = 1'b1; cnt = PCNT_W'(1024); ext_shift = 4'd9;  end
          8'h1C: begin hit = 1'b1; cnt = PCNT_W'(2048); ext_shift = 4'd9;  end
          8'h24: begin hit = 1'b1; cnt = PCNT_W'(4096); ext_shift = 4'd9;  end
          8'h2C: begin hit = 1'b1; cnt = PCNT_W'(4096); ext_shift = 4'd10; end
          8'h34: begin hit = 1'b1; cnt = PCNT_W'(8192); ext_shift = 4'd10; end
          8'h38, 8'h3C: begin hit = 1'b1; cnt = PCNT_W'(8192); ext_shift = 4'd11; end
          default: hit = 1'b0;
        endcase
      end
    end else begin
      case (dev_id)
        16'h2200: begin hit = 1'b1; dual = 1'b1; cnt = PCNT_W'(512);  ext_shift = 4'd9;  end
        16'h2300: begin hit = 1'b1; dual = 1'b1; cnt = PCNT_W'(1024); ext_shift = 4'd9;  end
        16'h2400: begin hit = 1'b1; dual = 1'b1; cnt = PCNT_W'(2048); ext_shift = 4'd9;  end
        16'h2500: begin hit = 1'b1; dual = 1'b1; cnt = PCNT_W'(4096); ext_shift = 4'd9;  end
        16'h2600: begin hit = 1'b1; dual = 1'b1; cnt = PCNT_W'(4096); ext_shift = 4'd10; end
        16'h2700: begin hit = 1'b1; dual = 1'b0; cnt = PCNT_W'(8192); ext_shift = 4'd10; end
        16'h2701: begin hit = 1'b1; dual = 1'b1; cnt = PCNT_W'(8192); ext_shift = 4'd10; end
        16'h2800: begin hit = 1'b1; dual = 1'b1; cnt = PCNT_W'(8192); ext_shift = 4'd11; end
        default:  hit = 1'b0;
      endcase
    end
  end

  // Extended size = 2^(s-1) + 2^(s-6); binary size = 2^(s-1) with shift s-1.
  assign pow2_part = PSIZE_W'(1) << (ext_shift - SHIFT_W'(1));
  assign tail_part = PSIZE_W'(1) << (ext_shift - SHIFT_W'(6));

  always_comb begin
    geo = '0;
    if (hit) begin
      geo.pcnt = cnt;
      if (dual && status[0]) begin
        geo.psize = pow2_part;
        geo.shift = ext_shift - SHIFT_W'(1);
      end else begin
        geo.psize = pow2_part + tail_part;
        geo.shift = ext_shift;
      end
    end
  end
endmodule

// File: rtl/fp_probe_fsm.sv
module fp_probe_fsm
  import flash_probe_pkg::*;
#(
  parameter logic [7:0] MFR_CODE   = 8'h1F,
  parameter logic [7:0] CMD_ID     = 8'h9F,
  parameter logic [7:0] CMD_STATUS = 8'hD7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        sh_done,
  input  logic [7:0]  sh_rx,
  output logic        sh_go,
  output logic [7:0]  sh_tx,
  output logic        cs_n,
  output logic        legacy,
  output logic [15:0] dev_id,
  output logic [7:0]  status,
  input  logic        hit,
  input  logic        dual,
  input  geo_t        geo,
  output geo_t        geo_out,
  output logic        valid,
  output logic        unsup
);
  probe_state_t st;
  logic [7:0]   mfr_q;

  assign legacy = (mfr_q != MFR_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      sh_go   <= 1'b0;
      sh_tx   <= '0;
      cs_n    <= 1'b1;
      mfr_q   <= '0;
      dev_id  <= '0;
      status  <= '0;
      geo_out <= '0;
      valid   <= 1'b0;
      unsup   <= 1'b0;
    end else begin
      sh_go <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cs_n <= 1'b0; sh_go <= 1'b1; sh_tx <= CMD_ID; st <= S_ID_OP;
        end
        S_ID_OP: if (sh_done) begin
          sh_go <= 1'b1; sh_tx <= 8'h00; st <= S_ID_MFR;
        end
        S_ID_MFR: if (sh_done) begin
          mfr_q <= sh_rx; sh_go <= 1'b1; st <= S_ID_HI;
        end
        S_ID_HI: if (sh_done) begin
          dev_id[15:8] <= sh_rx; sh_go <= 1'b1; st <= S_ID_LO;
        end
        S_ID_LO: if (sh_done) begin
          dev_id[7:0] <= sh_rx; cs_n <= 1'b1; st <= S_EVAL;
        end
        S_EVAL: begin
          if (legacy || (hit && dual)) begin
            st <= S_GAP;
          end else if (hit) begin
            geo_out <= geo; valid <= 1'b1; st <= S_DONE;
          end else begin
            unsup <= 1'b1; st <= S_DONE;
          end
        end
        S_GAP: begin
          cs_n <= 1'b0; sh_go <= 1'b1; sh_tx <= CMD_STATUS; st <= S_ST_OP;
        end
        S_ST_OP: if (sh_done) begin
          sh_go <= 1'b1; sh_tx <= 8'h00; st <= S_ST_RD;
        end
        S_ST_RD: if (sh_done) begin
          status <= sh_rx; cs_n <= 1'b1; st <= S_FINAL;
        end
        S_FINAL: begin
          if (hit) begin
            geo_out <= geo; valid <= 1'b1;
          end else begin
            unsup <= 1'b1;
          end
          st <= S_DONE;
        end
        S_DONE: st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_geom_probe.sv
module flash_geom_probe
  import flash_probe_pkg::*;
#(
  parameter int         CLK_DIV    = 4,
  parameter logic [7:0] MFR_CODE   = 8'h1F,
  parameter logic [7:0] CMD_ID     = 8'h9F,
  parameter logic [7:0] CMD_STATUS = 8'hD7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic               flash_sclk,
  output logic               flash_cs_n,
  output logic               flash_mosi,
  input  logic               flash_miso,
  output logic [PCNT_W-1:0]  page_count,
  output logic [PSIZE_W-1:0] page_size,
  output logic [SHIFT_W-1:0] page_shift,
  output logic               geo_valid,
  output logic               geo_unsupported
);
  logic        sh_go, sh_done, legacy, hit, dual;
  logic [7:0]  sh_tx, sh_rx, status;
  logic [15:0] dev_id;
  geo_t        geo, geo_out;

  fp_spi_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .go(sh_go), .tx_byte(sh_tx), .rx_byte(sh_rx),
    .done(sh_done), .sclk(flash_sclk), .mosi(flash_mosi), .miso(flash_miso)
  );

  fp_geo_decode u_dec (
    .legacy(legacy), .dev_id(dev_id), .status(status),
    .hit(hit), .dual(dual), .geo(geo)
  );

  fp_probe_fsm #(.MFR_CODE(MFR_CODE), .CMD_ID(CMD_ID), .CMD_STATUS(CMD_STATUS)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .sh_done(sh_done), .sh_rx(sh_rx),
    .sh_go(sh_go), .sh_tx(sh_tx), .cs_n(flash_cs_n), .legacy(legacy),
    .dev_id(dev_id), .status(status), .hit(hit), .dual(dual), .geo(geo),
    .geo_out(geo_out), .valid(geo_valid), .unsup(geo_unsupported)
  );

  assign page_count = geo_out.pcnt;
  assign page_size  = geo_out.psize;
  assign page_shift = geo_out.shift;
endmodule

// File: rtl/fp_probe_checker.sv
module fp_probe_checker
  import flash_probe_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               flash_sclk,
  input logic               flash_cs_n,
  input logic [PCNT_W-1:0]  page_count,
  input logic [PSIZE_W-1:0] page_size,
  input logic [SHIFT_W-1:0] page_shift,
  input logic               geo_valid,
  input logic               geo_unsupported
);
  logic [31:0] bin_sz, ext_sz;
  assign bin_sz = 32'd1 << page_shift;
  assign ext_sz = (32'd1 << (page_shift - 4'd1)) + (32'd1 << (page_shift - 4'd6));

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flash_cs_n && !flash_sclk && !geo_valid && !geo_unsupported)); // R1
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    flash_cs_n |-> !flash_sclk); // R2
  AST_SIZE_FORM: assert property (@(posedge clk) disable iff (rst)
    geo_valid |-> (32'(page_size) == bin_sz || 32'(page_size) == ext_sz)); // R4
  AST_COUNT_POW2: assert property (@(posedge clk) disable iff (rst)
    geo_valid |-> ($countones(page_count) == 1)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(geo_valid) || $past(geo_unsupported)) |->
      ($stable(page_count) && $stable(page_size) && $stable(page_shift) &&
       $stable(geo_valid) && $stable(geo_unsupported) && flash_cs_n)); // R11
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(geo_valid && geo_unsupported)); // R12
endmodule

bind flash_geom_probe fp_probe_checker u_chk (
  .clk(clk), .rst(rst), .flash_sclk(flash_sclk), .flash_cs_n(flash_cs_n),
  .page_count(page_count), .page_size(page_size), .page_shift(page_shift),
  .geo_valid(geo_valid), .geo_unsupported(geo_unsupported)
);

// File: tb/sim_flash_geom_probe.sv
module sim_flash_geom_probe;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        flash_sclk, flash_cs_n, flash_mosi;
  logic        flash_miso = 1'b0;
  logic [13:0] page_count;
  logic [10:0] page_size;
  logic [3:0]  page_shift;
  logic        geo_valid, geo_unsupported;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_geom_probe #(.CLK_DIV(2)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .flash_sclk(flash_sclk), .flash_cs_n(flash_cs_n),
    .flash_mosi(flash_mosi), .flash_miso(flash_miso),
    .page_count(page_count), .page_size(page_size), .page_shift(page_shift),
    .geo_valid(geo_valid), .geo_unsupported(geo_unsupported)
  );

  // Behavioural flash: mode 0, samples on rising, drives on falling.
  logic [7:0]  mdl_mfr = 8'h00;
  logic [15:0] mdl_id  = 16'h0000;
  logic [7:0]  mdl_st  = 8'h00;
  logic [7:0]  op_sh = 8'h00, op_last = 8'h00, op_prev = 8'h00;
  logic [23:0] resp = 24'h0;
  int          bitn = 0;
  int          txn_cnt = 0;

  always @(posedge flash_sclk or negedge flash_cs_n) begin
    if (!flash_sclk) begin
      bitn = 0;
      txn_cnt = txn_cnt + 1;
    end else if (!flash_cs_n) begin
      if (bitn < 8) op_sh = {op_sh[6:0], flash_mosi};
      bitn = bitn + 1;
      if (bitn == 8) begin
        op_prev = op_last;
        op_last = op_sh;
        if (op_sh == 8'h9F) resp = {mdl_mfr, mdl_id};
        else if (op_sh == 8'hD7) resp = {mdl_st, mdl_st, mdl_st};
        else resp = 24'h0;
      end
    end
  end

  always @(negedge flash_sclk) begin
    if (!flash_cs_n && bitn >= 8 && bitn < 32) flash_miso = resp[23 - (bitn - 8)];
    else flash_miso = 1'b0;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Resets, loads the model, probes; returns the number of transactions.
  task automatic probe(input logic [7:0] m, input logic [15:0] id,
                       input logic [7:0] st, output int txns);
    int base;
    int n;
    mdl_mfr = m; mdl_id = id; mdl_st = st;
    do_reset();
    base = txn_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!(geo_valid || geo_unsupported) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk("R12 probe finished", int'(n < 5000), 1);
    chk("R12 flags exclusive", int'(geo_valid && geo_unsupported), 0);
    txns = txn_cnt - base;
  endtask

  task automatic expect_geo(input string req, input int cnt, input int sz, input int sh);
    chk(req, int'(geo_valid), 1);
    chk(req, int'(geo_unsupported), 0);
    chk(req, int'(page_count), cnt);
    chk(req, int'(page_size), sz);
    chk(req, int'(page_shift), sh);
  endtask

  task automatic t_reset();
    do_reset();
    repeat (5) @(negedge clk);
    chk("R1 cs_n idle", int'(flash_cs_n), 1);
    chk("R1 sclk idle", int'(flash_sclk), 0);
    chk("R1 valid low", int'(geo_valid), 0);
    chk("R1 unsup low", int'(geo_unsupported), 0);
    chk("R1 count zero", int'(page_count), 0);
  endtask

  task automatic t_jedec_binary();
    int t;
    probe(8'h1F, 16'h2200, 8'h01, t);
    chk("R2 id opcode", int'(op_prev), 'h9F);
    chk("R3 status opcode", int'(op_last), 'hD7);
    chk("R3 two transactions", t, 2);
    expect_geo("R3 R5 2200 binary", 512, 256, 8);
    probe(8'h1F, 16'h2701, 8'h8D, t);
    expect_geo("R3 R5 2701 binary", 8192, 512, 9);
    probe(8'h1F, 16'h2800, 8'h81, t);
    expect_geo("R3 R5 2800 binary", 8192, 1024, 10);
  endtask

  task automatic t_jedec_ext();
    int t;
    probe(8'h1F, 16'h2800, 8'h00, t);
    expect_geo("R4 R5 2800 extended", 8192, 1056, 11);
    probe(8'h1F, 16'h2600, 8'h80, t);
    expect_geo("R4 R5 2600 extended", 4096, 528, 10);
    probe(8'h1F, 16'h2400, 8'hA4, t);
    expect_geo("R4 R5 2400 extended", 2048, 264, 9);
    probe(8'h1F, 16'h2300, 8'h01, t);
    expect_geo("R3 R5 2300 binary", 1024, 256, 8);
  endtask

  task automatic t_fixed();
    int t;
    probe(8'h1F, 16'h2700, 8'h81, t);
    chk("R6 single transaction", t, 1);
    chk("R6 last opcode id", int'(op_last), 'h9F);
    expect_geo("R6 2700 fixed", 8192, 528, 10);
  endtask

  task automatic t_unknown_id();
    int t;
    probe(8'h1F, 16'h4400, 8'h9C, t);
    chk("R7 unsupported", int'(geo_unsupported), 1);
    chk("R7 no status read", t, 1);
  endtask

  task automatic t_legacy();
    int t;
    probe(8'h00, 16'h0000, 8'h9C, t);
    chk("R8 status read", t, 2);
    chk("R8 status opcode", int'(op_last), 'hD7);
    expect_geo("R8 code 1C", 2048, 264, 9);
    probe(8'h7E, 16'h1234, 8'hB8, t);
    expect_geo("R8 code 38", 8192, 1056, 11);
    probe(8'h00, 16'h0000, 8'hAC, t);
    expect_geo("R8 code 2C", 4096, 528, 10);
    probe(8'h00, 16'h0000, 8'h8C, t);
    expect_geo("R8 code 0C", 512, 264, 9);
  endtask

  task automatic t_absent();
    int t;
    probe(8'hFF, 16'hFFFF, 8'hFF, t);
    chk("R9 status FF", int'(geo_unsupported), 1);
    chk("R9 status FF no valid", int'(geo_valid), 0);
    probe(8'h00, 16'h0000, 8'h00, t);
    chk("R9 status 00", int'(geo_unsupported), 1);
  endtask

  task automatic t_bad_code();
    int t;
    probe(8'h00, 16'h0000, 8'h90, t);
    chk("R10 code 10", int'(geo_unsupported), 1);
    chk("R10 code 10 no valid", int'(geo_valid), 0);
  endtask

  task automatic t_hold();
    int t;
    int base;
    probe(8'h1F, 16'h2500, 8'h00, t);
    expect_geo("R5 2500 extended", 4096, 264, 9);
    base = txn_cnt;
    mdl_id = 16'h2200;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (300) @(negedge clk);
    chk("R11 no new transaction", txn_cnt - base, 0);
    chk("R11 cs_n high", int'(flash_cs_n), 1);
    expect_geo("R11 result held", 4096, 264, 9);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_jedec_binary();
    t_jedec_ext();
    t_fixed();
    t_unknown_id();
    t_legacy();
    t_absent();
    t_bad_code();
    t_hold();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule